// File: doc/BRIEF.md
# Accumulator-File Instruction Decoder and ALU

This block is the execution stage of a small 8-bit accumulator machine with 14-bit instruction words. It takes an instruction, the working register W, one byte read from the register file and the current carry, digit-carry and zero flags. It returns an 8-bit result, one write strobe toward W or toward the file register, the next flag values, and a mask that shows which flags the instruction updates. The block has no internal state. Every output is a combinational function of the present inputs.

The surrounding sequencer reads the file operand before it presents the instruction. It stores the result wherever the strobes point and uses the skip request to drop the next instruction. Instructions that only move the program counter (calls, jumps, returns without a literal, sleep and watchdog clears) pass through this block with no write and no flag change. For the skip forms the sequencer gets a dedicated result-is-zero output and a skip request.

The bit layouts used below are as follows. In the byte group, bits 13:12 are 00, bits 11:8 hold the operation code, bit 7 is the destination bit d, and bits 6:0 hold the file address. In the bit group, bits 13:12 are 01, bits 11:10 hold the operation, and bits 9:7 hold the bit index. In the literal group, bits 13:12 are 11, and bits 7:0 hold the literal k. `flag_mask` bit 2 is carry, bit 1 is digit carry and bit 0 is zero.

Top module: `afu_core`

## Requirements
- R1: For byte-group codes 0010 to 1111, d=1 asserts `wr_f` and d=0 asserts `wr_w`. The two strobes are never high together.
- R2: Add (byte code 0111, literal 11111x) gives operand+W. Subtract (byte code 0010, literal 11110x) gives operand−W, where the operand is the file byte or k. Both set mask 111. C is the carry out of bit 7, and for subtraction C=1 means no borrow. DC is the carry out of bit 3, again inverted for borrow. Z is set when the result is zero.
- R3: Byte code 1101 rotates the file byte left through carry, and code 1100 rotates it right through carry. The bit shifted out becomes C, and the mask is 100.
- R4: AND (0101), OR (0100), XOR (0110), move (1000), complement (1001), increment (1010) and decrement (0011) set mask 001. The literal AND, OR and XOR forms (111001, 111000, 111010) also set mask 001. Z is set exactly when the 8-bit result is zero.
- R5: A flag outside the mask leaves its output equal to its input. Swap (1110) exchanges the two nibbles with mask 000.
- R6: Byte code 0001 with d=1 writes zero to the file, and with d=0 writes zero to W. Both set mask 001. Byte code 0000 with d=1 writes W to the file with mask 000.
- R7: Bit op 00 clears bit b of the file byte and op 01 sets it, writing the file. Ops 10 and 11 write nothing. They request a skip when bit b is clear (10) or set (11). All four have mask 000.
- R8: Literal codes 1100xx and 1101xx write k to W with mask 000. The literal logic and arithmetic forms write their result to W, and the x bits have no effect.
- R9: The increment-skip (1111) and decrement-skip (1011) forms write like their plain forms with mask 000, and request a skip when the result is zero. `res_zero` is high exactly when the result is zero, for every instruction.
- R10: Byte code 0000 with d=0, every 10xxxx word and literal code 1011 write nothing, have mask 000 and request no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Byte read from the addressed file register |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit-carry flag |
| z_in | input | 1 | Current zero flag |
| result | output | 8 | Computed value |
| wr_w | output | 1 | Store result into W |
| wr_f | output | 1 | Store result into the file register |
| flag_mask | output | 3 | Flags updated by this instruction {C,DC,Z} |
| c_out | output | 1 | Next carry flag |
| dc_out | output | 1 | Next digit-carry flag |
| z_out | output | 1 | Next zero flag |
| res_zero | output | 1 | Result equals zero |
| skip_req | output | 1 | Skip the following instruction |

## Verification
The embedded checks assume the inputs are settled, two-state values whenever they are evaluated. They also assume the flag inputs are the previous flag state, with no relation required to the other inputs. The bench changes every input at one clock edge and samples at the opposite edge, so nothing is observed mid-change. It sweeps every byte and bit code against all 256 file values, and every literal code against all 256 literals. W is drawn from values that hit the nibble and byte carry boundaries, and both carry inputs are used.

// File: rtl/afu_pkg.sv
package afu_pkg;
    localparam int DATA_W  = 8;
    localparam int HALF_W  = DATA_W / 2;
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int INSTR_W = DATA_W + 6;
    localparam int FLG_W   = 3;
    localparam int FLG_C   = 2;
    localparam int FLG_DC  = 1;
    localparam int FLG_Z   = 0;

    typedef enum logic [3:0] {
        OP_PASS_A, OP_PASS_W, OP_ZERO, OP_ADD, OP_SUB, OP_AND, OP_IOR,
        OP_XOR, OP_COM, OP_INC, OP_DEC, OP_ROL, OP_ROR, OP_SWAP,
        OP_BCLR, OP_BSET
    } alu_op_e;

    typedef enum logic [1:0] {SK_NONE, SK_ZERO, SK_BCLR, SK_BSET} skip_e;

    typedef struct packed {
        alu_op_e             op;
        logic                use_lit;
        logic                wr_w;
        logic                wr_f;
        logic [FLG_W-1:0]    mask;
        logic [BIT_W-1:0]    bit_idx;
        logic [DATA_W-1:0]   lit;
        skip_e               skip;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              half;
    } alu_t;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
        logic zero;
        logic skip;
    } stat_t;
endpackage

// File: rtl/afu_decode.sv
module afu_decode
    import afu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam logic [FLG_W-1:0] M_NONE = 3'b000;
    localparam logic [FLG_W-1:0] M_Z    = 3'b001;
    localparam logic [FLG_W-1:0] M_C    = 3'b100;
    localparam logic [FLG_W-1:0] M_ALL  = 3'b111;

    dec_t       dec_d;
    logic [3:0] code;
    logic       dbit;

    always_comb begin
        code          = instr[DATA_W+3:DATA_W];
        dbit          = instr[DATA_W-1];
        dec_d         = '0;
        dec_d.op      = OP_PASS_A;
        dec_d.skip    = SK_NONE;
        dec_d.mask    = M_NONE;
        dec_d.bit_idx = instr[DATA_W-1+BIT_W:DATA_W-1];
        dec_d.lit     = instr[DATA_W-1:0];
        unique case (instr[INSTR_W-1:INSTR_W-2])
            2'b00: begin
                if (code == 4'b0000) begin
                    if (dbit) begin
                        dec_d.op   = OP_PASS_W;
                        dec_d.wr_f = 1'b1;
                    end
                end else if (code == 4'b0001) begin
                    dec_d.op   = OP_ZERO;
                    dec_d.mask = M_Z;
                    dec_d.wr_f = dbit;
                    dec_d.wr_w = !dbit;
                end else begin
                    dec_d.wr_f = dbit;
                    dec_d.wr_w = !dbit;
                    case (code)
                        4'b0111: begin dec_d.op = OP_ADD;  dec_d.mask = M_ALL; end
                        4'b0010: begin dec_d.op = OP_SUB;  dec_d.mask = M_ALL; end
                        4'b0101: begin dec_d.op = OP_AND;  dec_d.mask = M_Z;   end
                        4'b0100: begin dec_d.op = OP_IOR;  dec_d.mask = M_Z;   end
                        4'b0110: begin dec_d.op = OP_XOR;  dec_d.mask = M_Z;   end
                        4'b1000: begin dec_d.op = OP_PASS_A; dec_d.mask = M_Z; end
                        4'b1001: begin dec_d.op = OP_COM;  dec_d.mask = M_Z;   end
                        4'b1010: begin dec_d.op = OP_INC;  dec_d.mask = M_Z;   end
                        4'b0011: begin dec_d.op = OP_DEC;  dec_d.mask = M_Z;   end
                        4'b1111: begin dec_d.op = OP_INC;  dec_d.skip = SK_ZERO; end
                        4'b1011: begin dec_d.op = OP_DEC;  dec_d.skip = SK_ZERO; end
                        4'b1101: begin dec_d.op = OP_ROL;  dec_d.mask = M_C;   end
                        4'b1100: begin dec_d.op = OP_ROR;  dec_d.mask = M_C;   end
                        default: dec_d.op = OP_SWAP;
                    endcase
                end
            end
            2'b01: begin
                unique case (instr[DATA_W+3:DATA_W+2])
                    2'b00: begin dec_d.op = OP_BCLR; dec_d.wr_f = 1'b1; end
                    2'b01: begin dec_d.op = OP_BSET; dec_d.wr_f = 1'b1; end
                    2'b10: dec_d.skip = SK_BCLR;
                    default: dec_d.skip = SK_BSET;
                endcase
            end
            2'b10: begin
                dec_d.op = OP_PASS_A;
            end
            default: begin
                dec_d.use_lit = 1'b1;
                casez (code)
                    4'b00??, 4'b01??: dec_d.wr_w = 1'b1;
                    4'b1000: begin dec_d.op = OP_IOR; dec_d.mask = M_Z; dec_d.wr_w = 1'b1; end
                    4'b1001: begin dec_d.op = OP_AND; dec_d.mask = M_Z; dec_d.wr_w = 1'b1; end
                    4'b1010: begin dec_d.op = OP_XOR; dec_d.mask = M_Z; dec_d.wr_w = 1'b1; end
                    4'b110?: begin dec_d.op = OP_SUB; dec_d.mask = M_ALL; dec_d.wr_w = 1'b1; end
                    4'b111?: begin dec_d.op = OP_ADD; dec_d.mask = M_ALL; dec_d.wr_w = 1'b1; end
                    default: dec_d.op = OP_PASS_A;
                endcase
            end
        endcase
    end

    assign dec = dec_d;

    always_comb begin
        p_one_dest_r1: assert (!(dec_d.wr_w && dec_d.wr_f))
            else $error("R1 both destinations selected");
        p_skip_noflag_r9: assert ((dec_d.skip == SK_NONE) || (dec_d.mask == M_NONE))
            else $error("R9 skip form updates flags");
    end
endmodule

// File: rtl/afu_alu.sv
module afu_alu
    import afu_pkg::*;
(
    input  alu_op_e            op,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  w_in,
    input  logic [BIT_W-1:0]   bit_idx,
    input  logic               c_in,
    output alu_t               res
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    alu_t              res_d;
    logic [DATA_W:0]   sum;
    logic [HALF_W:0]   hsum;
    logic [DATA_W-1:0] bmask;

    always_comb begin
        res_d       = '0;
        res_d.carry = c_in;
        sum         = '0;
        hsum        = '0;
        bmask       = ONE << bit_idx;
        case (op)
            OP_ADD: begin
                sum  = {1'b0, opa} + {1'b0, w_in};
                hsum = {1'b0, opa[HALF_W-1:0]} + {1'b0, w_in[HALF_W-1:0]};
                res_d.value = sum[DATA_W-1:0];
                res_d.carry = sum[DATA_W];
                res_d.half  = hsum[HALF_W];
            end
            OP_SUB: begin
                sum  = {1'b0, opa} + {1'b0, ~w_in} + {{DATA_W{1'b0}}, 1'b1};
                hsum = {1'b0, opa[HALF_W-1:0]} + {1'b0, ~w_in[HALF_W-1:0]}
                     + {{HALF_W{1'b0}}, 1'b1};
                res_d.value = sum[DATA_W-1:0];
                res_d.carry = sum[DATA_W];
                res_d.half  = hsum[HALF_W];
            end
            OP_AND:    res_d.value = opa & w_in;
            OP_IOR:    res_d.value = opa | w_in;
            OP_XOR:    res_d.value = opa ^ w_in;
            OP_PASS_W: res_d.value = w_in;
            OP_ZERO:   res_d.value = '0;
            OP_COM:    res_d.value = ~opa;
            OP_INC:    res_d.value = opa + ONE;
            OP_DEC:    res_d.value = opa - ONE;
            OP_ROL: begin
                res_d.value = {opa[DATA_W-2:0], c_in};
                res_d.carry = opa[DATA_W-1];
            end
            OP_ROR: begin
                res_d.value = {c_in, opa[DATA_W-1:1]};
                res_d.carry = opa[0];
            end
            OP_SWAP:   res_d.value = {opa[HALF_W-1:0], opa[DATA_W-1:HALF_W]};
            OP_BCLR:   res_d.value = opa & ~bmask;
            OP_BSET:   res_d.value = opa | bmask;
            default:   res_d.value = opa;
        endcase
    end

    assign res = res_d;
endmodule

// File: rtl/afu_status.sv
module afu_status
    import afu_pkg::*;
(
    input  logic [FLG_W-1:0]  mask,
    input  skip_e             skip,
    input  logic [BIT_W-1:0]  bit_idx,
    input  alu_t              alu,
    input  logic              c_in,
    input  logic              dc_in,
    input  logic              z_in,
    output stat_t             stat
);
    stat_t stat_d;

    always_comb begin
        stat_d.zero = (alu.value == '0);
        stat_d.c    = mask[FLG_C]  ? alu.carry   : c_in;
        stat_d.dc   = mask[FLG_DC] ? alu.half    : dc_in;
        stat_d.z    = mask[FLG_Z]  ? stat_d.zero : z_in;
        unique case (skip)
            SK_ZERO: stat_d.skip = stat_d.zero;
            SK_BCLR: stat_d.skip = !alu.value[bit_idx];
            SK_BSET: stat_d.skip = alu.value[bit_idx];
            default: stat_d.skip = 1'b0;
        endcase
    end

    assign stat = stat_d;
endmodule

// File: rtl/afu_core.sv
module afu_core
    import afu_pkg::*;
(
    input  logic [13:0] instr,
    input  logic [7:0]  w_in,
    input  logic [7:0]  f_in,
    input  logic        c_in,
    input  logic        dc_in,
    input  logic        z_in,
    output logic [7:0]  result,
    output logic        wr_w,
    output logic        wr_f,
    output logic [2:0]  flag_mask,
    output logic        c_out,
    output logic        dc_out,
    output logic        z_out,
    output logic        res_zero,
    output logic        skip_req
);
    dec_t              dec;
    alu_t              alu;
    stat_t             stat;
    logic [DATA_W-1:0] opa_d;

    afu_decode u_dec (.instr(instr), .dec(dec));

    always_comb opa_d = dec.use_lit ? dec.lit : f_in;

    afu_alu u_alu (
        .op(dec.op), .opa(opa_d), .w_in(w_in), .bit_idx(dec.bit_idx),
        .c_in(c_in), .res(alu)
    );

    afu_status u_stat (
        .mask(dec.mask), .skip(dec.skip), .bit_idx(dec.bit_idx), .alu(alu),
        .c_in(c_in), .dc_in(dc_in), .z_in(z_in), .stat(stat)
    );

    assign result    = alu.value;
    assign wr_w      = dec.wr_w;
    assign wr_f      = dec.wr_f;
    assign flag_mask = dec.mask;
    assign c_out     = stat.c;
    assign dc_out    = stat.dc;
    assign z_out     = stat.z;
    assign res_zero  = stat.zero;
    assign skip_req  = stat.skip;

    always_comb begin
        p_z_exact_r4: assert (!flag_mask[FLG_Z] || (z_out == (result == 8'h00)))
            else $error("R4 zero flag disagrees with result");
        p_keep_flags_r5: assert ((flag_mask[FLG_C] || c_out == c_in) &&
                                 (flag_mask[FLG_DC] || dc_out == dc_in) &&
                                 (flag_mask[FLG_Z] || z_out == z_in))
            else $error("R5 unmasked flag changed");
        p_rot_carry_r3: assert (flag_mask != 3'b100 ||
                                result == {f_in[6:0], c_in} || result == {c_in, f_in[7:1]})
            else $error("R3 rotate result not from file byte and carry");
        p_skip_noflag_r9: assert (!skip_req || flag_mask == 3'b000)
            else $error("R9 skip raised with flag update");
        p_no_out_write_r10: assert (instr[13:12] != 2'b10 || (!wr_w && !wr_f))
            else $error("R10 control word writes a register");
    end
endmodule

// File: tb/tb_afu_core.sv
module tb_afu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] instr = '0;
    logic [7:0]  w_in = '0, f_in = '0;
    logic        c_in = 1'b0, dc_in = 1'b0, z_in = 1'b0;
    logic [7:0]  result;
    logic        wr_w, wr_f, c_out, dc_out, z_out, res_zero, skip_req;
    logic [2:0]  flag_mask;
    int          n_checks = 0, n_fail = 0, cycles = 0;

    always #2 clk = ~clk;

    afu_core dut (
        .instr(instr), .w_in(w_in), .f_in(f_in), .c_in(c_in), .dc_in(dc_in),
        .z_in(z_in), .result(result), .wr_w(wr_w), .wr_f(wr_f),
        .flag_mask(flag_mask), .c_out(c_out), .dc_out(dc_out), .z_out(z_out),
        .res_zero(res_zero), .skip_req(skip_req)
    );

    // Expected {result, wr_w, wr_f, mask, c, dc, z, res_zero, skip}
    function automatic logic [17:0] model(logic [13:0] ins, logic [7:0] w,
                                          logic [7:0] f, logic c, logic dc, logic z);
        int r, nc, ndc, k, code, b;
        logic ww, wf, sk, d;
        logic [2:0] m;
        r = f; nc = c; ndc = dc; ww = 0; wf = 0; sk = 0; m = 0;
        k = ins[7:0]; code = ins[11:8]; d = ins[7]; b = ins[9:7];
        case (ins[13:12])
            2'b00: begin
                if (code == 0) begin
                    if (d) begin r = w; wf = 1; end
                end else if (code == 1) begin
                    r = 0; m = 1; wf = d; ww = !d;
                end else begin
                    wf = d; ww = !d;
                    case (code)
                        7: begin r = f + w; m = 7; nc = (f + w > 255); ndc = (f % 16 + w % 16 > 15); end
                        2: begin r = f - w; m = 7; nc = (f >= w); ndc = (f % 16 >= w % 16); end
                        5: begin r = f & w; m = 1; end
                        4: begin r = f | w; m = 1; end
                        6: begin r = f ^ w; m = 1; end
                        8: begin r = f; m = 1; end
                        9: begin r = 255 - f; m = 1; end
                        10: begin r = f + 1; m = 1; end
                        3: begin r = f + 255; m = 1; end
                        15: begin r = (f + 1) % 256; sk = (r == 0); end
                        11: begin r = (f + 255) % 256; sk = (r == 0); end
                        13: begin r = f * 2 + c; nc = f / 128; m = 4; end
                        12: begin r = f / 2 + c * 128; nc = f % 2; m = 4; end
                        default: r = (f % 16) * 16 + f / 16;
                    endcase
                end
            end
            2'b01: begin
                case (ins[11:10])
                    0: begin r = f & ~(1 << b); wf = 1; end
                    1: begin r = f | (1 << b); wf = 1; end
                    2: sk = !f[b];
                    default: sk = f[b];
                endcase
            end
            2'b10: r = f;
            default: begin
                r = k;
                if (code < 8) ww = 1;
                else if (code == 8)  begin r = k | w; m = 1; ww = 1; end
                else if (code == 9)  begin r = k & w; m = 1; ww = 1; end
                else if (code == 10) begin r = k ^ w; m = 1; ww = 1; end
                else if (code == 11) r = k;
                else if (code < 14) begin r = k - w; m = 7; ww = 1; nc = (k >= w); ndc = (k % 16 >= w % 16); end
                else begin r = k + w; m = 7; ww = 1; nc = (k + w > 255); ndc = (k % 16 + w % 16 > 15); end
            end
        endcase
        r = r & 255;
        return {r[7:0], ww, wf, m, m[2] ? nc[0] : c, m[1] ? ndc[0] : dc,
                m[0] ? (r == 0) : z, (r == 0), sk};
    endfunction

    function automatic string tag(logic [13:0] ins);
        int code;
        code = ins[11:8];
        case (ins[13:12])
            2'b00: begin
                if (code == 0) return ins[7] ? "R6" : "R10";
                if (code == 1) return "R6";
                if (code == 7 || code == 2) return "R1,R2";
                if (code == 13 || code == 12) return "R1,R3";
                if (code == 15 || code == 11) return "R1,R9";
                if (code == 14) return "R1,R5";
                return "R1,R4";
            end
            2'b01: return "R7";
            2'b10: return "R10";
            default: begin
                if (code == 11) return "R10";
                if (code >= 12) return "R2,R8";
                if (code >= 8) return "R4,R8";
                return "R8";
            end
        endcase
    endfunction

    task automatic run(logic [13:0] ins, logic [7:0] w, logic [7:0] f,
                       logic c, logic dc, logic z);
        logic [17:0] exp_v, got;
        @(posedge clk);
        instr = ins; w_in = w; f_in = f; c_in = c; dc_in = dc; z_in = z;
        @(negedge clk);
        exp_v = model(ins, w, f, c, dc, z);
        got = {result, wr_w, wr_f, flag_mask, c_out, dc_out, z_out, res_zero, skip_req};
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s instr=%h w=%h f=%h c=%b: got %h expected %h",
                     tag(ins), ins, w, f, c, got, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] wset [5];
        wset[0] = 8'h00; wset[1] = 8'h01; wset[2] = 8'h0F; wset[3] = 8'h80; wset[4] = 8'hFF;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero word is a no-op (R10)
        run(14'h0000, 8'h5A, 8'hA5, 1'b1, 1'b0, 1'b1);
        // Byte group: R1..R6, R9
        for (int code = 0; code < 16; code++)
            for (int d = 0; d < 2; d++)
                for (int f = 0; f < 256; f++)
                    for (int wi = 0; wi < 5; wi++)
                        for (int c = 0; c < 2; c++)
                            run({2'b00, 4'(code), 1'(d), 7'h25}, wset[wi], 8'(f),
                                1'(c), ~1'(c), 1'(f));
        // Bit group: R7
        for (int op = 0; op < 4; op++)
            for (int b = 0; b < 8; b++)
                for (int f = 0; f < 256; f++)
                    run({2'b01, 2'(op), 3'(b), 7'h11}, 8'h3C, 8'(f), 1'(b), 1'(f), 1'(op));
        // Literal group: R2, R4, R8, R10
        for (int hi = 0; hi < 16; hi++)
            for (int k = 0; k < 256; k++)
                for (int wi = 1; wi < 5; wi++)
                    run({2'b11, 4'(hi), 8'(k)}, wset[wi], 8'h77, 1'(k), 1'(wi), 1'(hi));
        // Control words and low byte-space no-ops: R10
        for (int j = 0; j < 64; j++)
            run({2'b10, 12'(j * 61)}, 8'h12, 8'(j), 1'(j), 1'(j), 1'(j));
        for (int j = 0; j < 128; j++)
            run({7'b0000000, 7'(j)}, 8'hEE, 8'(j * 3), 1'(j), 1'(j), 1'(j));
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule